// File: doc/BRIEF.md
# Auto-Sleep ADC Conversion Sequencer

This block runs an external 8-bit converter with a parallel output bus in the mode where the converter switches itself off after every conversion. A start request raises the active-low convert line, which wakes the converter. The line then stays high for a programmable power-up interval before it falls to begin a conversion. The line is kept low after the converter's end-of-conversion strobe returns high, so the converter samples it low and goes to sleep.

The result is collected afterwards through active-low chip-select and read strobes. The byte is returned with a one-cycle valid flag. The convert line stays low while the controller is idle, so the converter sleeps until the next request. All intervals are counted in system clock cycles and set by parameters. A conversion timeout also ends the conversion phase if the end-of-conversion edge never arrives.

Top module: `adc_pd_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `cnv_n_o`, `cs_n_o` and `rd_n_o` are 1, and `valid_o` and `busy_o` are 0.
- R2: After a start is accepted in idle (including the first one after reset), `cnv_n_o` is 1 for exactly WAKE_CYC cycles, counted from the accepting clock edge, and then falls to 0.
- R3: `cnv_n_o` stays 0 from its falling edge through the whole read, and the strobes are never low while `cnv_n_o` is 1.
- R4: `cs_n_o` and `rd_n_o` are always equal, and each read holds them at 0 for exactly RD_CYC consecutive cycles.
- R5: The byte on `db_i` during the last strobe-low cycle appears on `data_o` with `valid_o` = 1 in the cycle right after the strobes return to 1, and `valid_o` lasts one cycle.
- R6: A start request while `busy_o` = 1 is ignored: it produces no extra result and does not raise `cnv_n_o`, and `cnv_n_o` only rises in the cycle after a start sampled while idle.
- R7: `busy_o` rises in the cycle after an accepted start, stays 1 through wake, conversion and read, and is 0 in the cycle that carries `valid_o`.
- R8: `eoc_i` idles at 1 and pulses to 0 during conversion. It passes through a two-flop synchroniser, and when it returns to 1 during conversion the strobes fall after the third rising clock edge following that return.
- R9: If no return of `eoc_i` is seen, the strobes fall after CONV_TMO_CYC cycles counted from the edge on which `cnv_n_o` fell.
- R10: After a conversion completes, `cnv_n_o` stays 0 while the controller is idle, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled on each clock edge |
| eoc_i | input | 1 | End-of-conversion strobe from the converter, low while active |
| db_i | input | DATA_W | Converter data bus |
| cnv_n_o | output | 1 | Active-low convert line; the rising edge wakes the converter |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| data_o | output | DATA_W | Captured conversion result |
| valid_o | output | 1 | One-cycle flag marking a new `data_o` |
| busy_o | output | 1 | Controller is not idle |

## Verification
The hardest case to reach from the ports is a start request that arrives while the convert line is already low mid-conversion. Accepting it would pulse the line high and corrupt the sleep handshake. The stimulus therefore raises `start_i` one cycle into the conversion phase, on runs that end through the strobe and on runs that end through the timeout. It checks that the line stays low and that exactly one result leaves per accepted start. The bus value is also flipped to its complement on every strobe cycle except the last, so a capture taken one cycle early or late shows up as a wrong byte.

// File: rtl/adc_pd_pkg.sv
package adc_pd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAKE = 2'd1,
      ST_CONV = 2'd2,
      ST_READ = 2'd3
   } pd_state_e;

endpackage

// File: rtl/adc_pd_sync.sv
module adc_pd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= RST_VAL;
      else        last_q <= q_o;
   end

   assign rise_o = q_o & ~last_q;

endmodule

// File: rtl/adc_pd_timer.sv
module adc_pd_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_pd_capture.sv
module adc_pd_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [DATA_W-1:0] db_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= take_i;
         if (take_i) data_o <= db_i;
      end
   end

endmodule

// File: rtl/adc_pd_ctrl.sv
module adc_pd_ctrl #(
   parameter int DATA_W       = 8,
   parameter int WAKE_CYC     = 20,
   parameter int CONV_TMO_CYC = 60,
   parameter int RD_CYC       = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              eoc_i,
   input  logic [DATA_W-1:0] db_i,
   output logic              cnv_n_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              busy_o
);
   import adc_pd_pkg::*;

   localparam int MAX_A   = (WAKE_CYC > CONV_TMO_CYC) ? WAKE_CYC : CONV_TMO_CYC;
   localparam int MAX_CYC = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 1);
   localparam logic [CNT_W-1:0] TMO_LD  = CNT_W'(CONV_TMO_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);

   generate
      if (DATA_W < 1 || WAKE_CYC < 1 || CONV_TMO_CYC < 1 || RD_CYC < 1) begin : g_bad_len
         $error("adc_pd_ctrl: widths and cycle counts must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("adc_pd_ctrl: SYNC_STAGES must be at least 1");
      end
   endgenerate

   pd_state_e        state_q, state_d;
   logic             cnv_n_q;
   logic             eoc_s, eoc_rise;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic             take;

   adc_pd_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_eoc_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (eoc_i),
      .q_o   (eoc_s),
      .rise_o(eoc_rise)
   );

   adc_pd_timer #(
      .W(CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(tmr_load),
      .val_i (tmr_val),
      .zero_o(tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      take     = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            state_d  = ST_WAKE;
            tmr_load = 1'b1;
            tmr_val  = WAKE_LD;
         end
         ST_WAKE: if (tmr_zero) begin
            state_d  = ST_CONV;
            tmr_load = 1'b1;
            tmr_val  = TMO_LD;
         end
         ST_CONV: if (eoc_rise || tmr_zero) begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = RD_LD;
         end
         ST_READ: if (tmr_zero) begin
            state_d = ST_IDLE;
            take    = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnv_n_q <= 1'b1;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && state_d == ST_WAKE)      cnv_n_q <= 1'b1;
         else if (state_q == ST_WAKE && state_d == ST_CONV) cnv_n_q <= 1'b0;
      end
   end

   adc_pd_capture #(
      .DATA_W(DATA_W)
   ) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .db_i   (db_i),
      .data_o (data_o),
      .valid_o(valid_o)
   );

   assign cnv_n_o = cnv_n_q;
   assign cs_n_o  = (state_q != ST_READ);
   assign rd_n_o  = (state_q != ST_READ);
   assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/adc_pd_chk.sv
module adc_pd_chk #(
   parameter int DATA_W       = 8,
   parameter int WAKE_CYC     = 20,
   parameter int CONV_TMO_CYC = 60,
   parameter int RD_CYC       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [DATA_W-1:0] db_i,
   input logic              cnv_n_o,
   input logic              cs_n_o,
   input logic              rd_n_o,
   input logic [DATA_W-1:0] data_o,
   input logic              valid_o,
   input logic              busy_o
);

   logic [15:0] hi_run, lo_run, conv_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run   <= '0;
         lo_run   <= '0;
         conv_run <= '0;
      end else begin
         hi_run   <= (cnv_n_o && busy_o) ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
         lo_run   <= (!rd_n_o) ? ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1) : '0;
         conv_run <= (!cnv_n_o && rd_n_o && busy_o) ?
                     ((conv_run == 16'hFFFF) ? conv_run : conv_run + 1'b1) : '0;
      end
   end

   p_wake_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnv_n_o) |-> hi_run == 16'(WAKE_CYC));

   p_read_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !cnv_n_o);

   p_strobes_paired_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o == rd_n_o);

   p_read_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> lo_run == 16'(RD_CYC));

   p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (rd_n_o && $past(!rd_n_o)));

   p_data_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> data_o == $past(db_i));

   p_rise_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_n_o) |-> $past(start_i && !busy_o));

   p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> !busy_o);

   p_conv_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_o) |-> (conv_run != 16'd0 && conv_run <= 16'(CONV_TMO_CYC)));

endmodule

bind adc_pd_ctrl adc_pd_chk #(
   .DATA_W      (DATA_W),
   .WAKE_CYC    (WAKE_CYC),
   .CONV_TMO_CYC(CONV_TMO_CYC),
   .RD_CYC      (RD_CYC)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .db_i   (db_i),
   .cnv_n_o(cnv_n_o),
   .cs_n_o (cs_n_o),
   .rd_n_o (rd_n_o),
   .data_o (data_o),
   .valid_o(valid_o),
   .busy_o (busy_o)
);

// File: tb/tb_adc_pd_ctrl.sv
module tb_adc_pd_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int WAKE = 6;
   localparam int TMO  = 20;
   localparam int RDC  = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start_i;
   logic          eoc_i;
   logic [DW-1:0] db_i;
   logic          cnv_n_o, cs_n_o, rd_n_o, valid_o, busy_o;
   logic [DW-1:0] data_o;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_pd_ctrl #(
      .DATA_W(DW), .WAKE_CYC(WAKE), .CONV_TMO_CYC(TMO), .RD_CYC(RDC), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .eoc_i(eoc_i), .db_i(db_i),
      .cnv_n_o(cnv_n_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
      .data_o(data_o), .valid_o(valid_o), .busy_o(busy_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // scoreboard monitor: every valid result is compared with the oldest expectation
   always @(negedge clk) begin
      if (rst_n === 1'b1 && valid_o === 1'b1) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected result", int'(data_o), -1);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(data_o == e, "R5", "result byte", int'(data_o), int'(e));
         end
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_conv(input logic [DW-1:0] val, input bit use_eoc, input bit poke);
      int n;
      int cnt;
      exp_q.push_back(val);
      db_i    = ~val;
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R7", "busy after start", int'(busy_o), 1);
      chk(cnv_n_o == 1'b1, "R2", "convert line raised for wake", int'(cnv_n_o), 1);
      repeat (WAKE - 1) step();
      chk(cnv_n_o == 1'b1, "R2", "still waking on last wake cycle", int'(cnv_n_o), 1);
      step();
      chk(cnv_n_o == 1'b0, "R2", "convert line falls after wake", int'(cnv_n_o), 0);
      n = 0;
      if (poke) begin
         start_i = 1'b1;
         step();
         n++;
         start_i = 1'b0;
         chk(cnv_n_o == 1'b0, "R6", "start while busy leaves line low", int'(cnv_n_o), 0);
         chk(busy_o == 1'b1, "R6", "start while busy keeps busy", int'(busy_o), 1);
      end
      if (use_eoc) begin
         eoc_i = 1'b0;
         repeat (3) step();
         eoc_i = 1'b1;
         repeat (2) step();
         chk(rd_n_o == 1'b1, "R8", "read not yet after two edges", int'(rd_n_o), 1);
         step();
         chk(rd_n_o == 1'b0, "R8", "read after third edge", int'(rd_n_o), 0);
      end else begin
         while (n < TMO - 1) begin
            step();
            n++;
         end
         chk(rd_n_o == 1'b1, "R9", "no read before timeout", int'(rd_n_o), 1);
         step();
         chk(rd_n_o == 1'b0, "R9", "read at timeout", int'(rd_n_o), 0);
      end
      cnt = 0;
      while (rd_n_o == 1'b0 && cnt < 50) begin
         chk(cs_n_o == 1'b0, "R4", "chip select with read", int'(cs_n_o), 0);
         chk(cnv_n_o == 1'b0, "R3", "line low during read", int'(cnv_n_o), 0);
         db_i = (cnt == RDC - 1) ? val : ~val;
         step();
         cnt++;
      end
      chk(cnt == RDC, "R4", "strobe length", cnt, RDC);
      chk(valid_o == 1'b1, "R5", "valid after strobe", int'(valid_o), 1);
      chk(busy_o == 1'b0, "R7", "idle in valid cycle", int'(busy_o), 0);
      db_i = ~val;
      step();
      chk(valid_o == 1'b0, "R5", "valid lasts one cycle", int'(valid_o), 0);
      repeat (4) step();
      chk(cnv_n_o == 1'b0, "R10", "converter left asleep in idle", int'(cnv_n_o), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n   = 1'b0;
      start_i = 1'b0;
      eoc_i   = 1'b1;
      db_i    = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(cnv_n_o == 1'b1 && cs_n_o == 1'b1 && rd_n_o == 1'b1, "R1", "lines in reset",
          int'({cnv_n_o, cs_n_o, rd_n_o}), 7);
      chk(valid_o == 1'b0 && busy_o == 1'b0, "R1", "flags in reset",
          int'({valid_o, busy_o}), 0);
      rst_n = 1'b1;
      step();
      chk(cnv_n_o == 1'b1 && rd_n_o == 1'b1 && busy_o == 1'b0, "R1", "idle after reset",
          int'({cnv_n_o, rd_n_o, busy_o}), 6);

      run_conv(8'h5A, 1'b1, 1'b0);
      run_conv(8'hFF, 1'b0, 1'b0);
      run_conv(8'h00, 1'b1, 1'b1);
      run_conv(8'hA5, 1'b0, 1'b1);
      run_conv(8'h3C, 1'b1, 1'b0);

      repeat (5) step();
      chk(exp_q.size() == 0, "R6", "one result per accepted start", exp_q.size(), 0);
      chk(cnv_n_o == 1'b0, "R10", "converter asleep at end", int'(cnv_n_o), 0);
      finish_run();
   end

endmodule